// File: doc/BRIEF.md
# Prioritized Interrupt Acceptance Unit

This unit sits beside a processor core's sequencer and decides, every cycle, whether an interrupt entry starts. It looks at the interrupt-enable flag, the current priority level held in the flag word, the interrupt table base, and a set of peripheral request lines. Each request line has its own 3-bit priority and vector number. Two other event inputs come from the instruction decoder: a software (table-based) interrupt with its own vector number, and a fixed-address interrupt whose vector location is supplied directly.

When an entry is accepted, the unit raises a one-cycle accept strobe. With it, the unit presents the vector table address, the new flag word, the new priority level, and the flag word and program counter that the core must save. For a peripheral entry it also returns a one-hot clear to the winning source. The unit does not push the stack and does not fetch from the table: the core does both with the values it is given.

Top module: `irq_accept`

## Requirements
- R1: A peripheral request is accepted only when flag bit 6 (interrupt enable) is 1, its request line is 1, and its priority is strictly greater than the level in flag bits 14:12. A request at a priority equal to the level is not taken. The same request is taken once the level drops below it.
- R2: When several peripheral requests qualify, the one with the highest priority wins. A tie goes to the lowest source index.
- R3: For peripheral and software entries, the vector address is the table base plus four times the vector number. For a fixed-address entry, the vector address is the supplied fixed location.
- R4: Every entry clears flag bit 6 (interrupt enable) and flag bit 1 (debug) in the new flag word.
- R5: Peripheral and fixed entries clear flag bit 7 (stack select). A software entry clears bit 7 only when its vector number is 31 or lower; otherwise bit 7 keeps its old value.
- R6: After a peripheral entry, new flag bits 14:12 hold the winner's priority, and `ipl_o` shows the same value. Software and fixed entries keep the old level.
- R7: The saved flag word and saved program counter are the flag and PC inputs of the deciding cycle, unmodified.
- R8: `take_o` and `clr_o` are registered and appear one clock after the deciding inputs. `clr_o` is one-hot to the winner for a peripheral entry and zero otherwise. No entry is accepted in the cycle in which `take_o` is high, so `take_o` is never high two cycles in a row.
- R9: The event classes are ranked fixed first, then software, then peripheral. A peripheral request that loses to another class is not cleared and stays pending.
- R10: While reset is high, and in the first cycle after it, `take_o` and `clr_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flags_i | input | 16 | Current flag word (bit 6 enable, bit 1 debug, bit 7 stack select, bits 14:12 level) |
| pc_i | input | ADDR_W | Current program counter |
| tbase_i | input | ADDR_W | Interrupt table base |
| req_i | input | NSRC | Peripheral request lines |
| prio_i | input | NSRC*3 | Per-source priorities; source i at bits 3i+2:3i |
| vec_i | input | NSRC*VEC_W | Per-source vector numbers; source i at bits VEC_W*i+VEC_W-1:VEC_W*i |
| sw_req_i | input | 1 | Software interrupt event |
| sw_vec_i | input | VEC_W | Software interrupt vector number |
| fix_req_i | input | 1 | Fixed-address interrupt event |
| fix_loc_i | input | ADDR_W | Fixed vector location |
| take_o | output | 1 | One-cycle accept strobe |
| vaddr_o | output | ADDR_W | Vector table address |
| flags_o | output | 16 | New flag word |
| ipl_o | output | 3 | New priority level |
| save_flags_o | output | 16 | Flag word to save |
| save_pc_o | output | ADDR_W | Program counter to save |
| clr_o | output | NSRC | One-hot request clear to the winning source |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a decoder event (fixed or software) and a pending peripheral request. The bench raises both in one cycle and judges the result by the vector address, by `clr_o` staying zero, and by the peripheral being taken two cycles later, after the blocked cycle.

The second pair is a held peripheral request and the strobe it has just produced. The bench holds the request and expects `take_o` low in the following cycle.

The equal-priority boundary is judged by a rejection at level 5, followed by acceptance once the level is lowered to 4.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;
  localparam int FLAG_W      = 16;
  localparam int BIT_DBG     = 1;
  localparam int BIT_IEN     = 6;
  localparam int BIT_STK     = 7;
  localparam int LVL_LSB     = 12;
  localparam int LVL_W       = 3;
  localparam int SW_STK_LAST = 31;

  typedef enum logic [1:0] {
    ENT_NONE   = 2'd0,
    ENT_PERIPH = 2'd1,
    ENT_SOFT   = 2'd2,
    ENT_FIXED  = 2'd3
  } entry_kind_e;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_accept_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int VEC_W = 6,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                    en_i,
  input  logic [LVL_W-1:0]        lvl_i,
  input  logic [NSRC-1:0]         req_i,
  input  logic [NSRC*LVL_W-1:0]   prio_i,
  input  logic [NSRC*VEC_W-1:0]   vec_i,
  output logic                    hit_o,
  output logic [LVL_W-1:0]        win_prio_o,
  output logic [VEC_W-1:0]        win_vec_o,
  output logic [NSRC-1:0]         win_1h_o
);
  logic [LVL_W-1:0] prio_v [NSRC];
  logic [VEC_W-1:0] vec_v  [NSRC];
  logic [NSRC-1:0]  qual;
  logic [IDX_W-1:0] best_idx;

  // One qualifier per source: enabled, requesting, strictly above the level.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign prio_v[g] = prio_i[g*LVL_W +: LVL_W];
    assign vec_v[g]  = vec_i[g*VEC_W +: VEC_W];
    assign qual[g]   = en_i && req_i[g] && (prio_v[g] > lvl_i);
  end

  // A strict greater-than keeps the lower index on a tie.
  always_comb begin
    hit_o      = 1'b0;
    best_idx   = '0;
    win_prio_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (qual[i] && (!hit_o || prio_v[i] > win_prio_o)) begin
        hit_o      = 1'b1;
        best_idx   = IDX_W'(i);
        win_prio_o = prio_v[i];
      end
    end
    win_vec_o = vec_v[best_idx];
    win_1h_o  = hit_o ? (NSRC'(1) << best_idx) : '0;
  end
endmodule

// File: rtl/irq_entry_calc.sv
module irq_entry_calc
  import irq_accept_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int VEC_W  = 6
) (
  input  entry_kind_e        kind_i,
  input  logic [FLAG_W-1:0]  flags_i,
  input  logic [ADDR_W-1:0]  tbase_i,
  input  logic [ADDR_W-1:0]  fix_loc_i,
  input  logic [VEC_W-1:0]   vec_i,
  input  logic [LVL_W-1:0]   prio_i,
  output logic [ADDR_W-1:0]  vaddr_o,
  output logic [FLAG_W-1:0]  flags_o
);
  localparam int PAD_W = ADDR_W - VEC_W - 2;

  logic [ADDR_W-1:0] slot_off;
  assign slot_off = {{PAD_W{1'b0}}, vec_i, 2'b00};

  always_comb begin
    flags_o          = flags_i;
    flags_o[BIT_IEN] = 1'b0;
    flags_o[BIT_DBG] = 1'b0;
    unique case (kind_i)
      ENT_PERIPH: begin
        flags_o[BIT_STK]              = 1'b0;
        flags_o[LVL_LSB +: LVL_W]     = prio_i;
      end
      ENT_FIXED:  flags_o[BIT_STK] = 1'b0;
      ENT_SOFT:   if (int'(vec_i) <= SW_STK_LAST) flags_o[BIT_STK] = 1'b0;
      default:    ;
    endcase
    vaddr_o = (kind_i == ENT_FIXED) ? fix_loc_i : (tbase_i + slot_off);
  end
endmodule

// File: rtl/irq_accept.sv
module irq_accept
  import irq_accept_pkg::*;
#(
  parameter int NSRC   = 4,
  parameter int VEC_W  = 6,
  parameter int ADDR_W = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              flags_i,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [ADDR_W-1:0]        tbase_i,
  input  logic [NSRC-1:0]          req_i,
  input  logic [NSRC*3-1:0]        prio_i,
  input  logic [NSRC*VEC_W-1:0]    vec_i,
  input  logic                     sw_req_i,
  input  logic [VEC_W-1:0]         sw_vec_i,
  input  logic                     fix_req_i,
  input  logic [ADDR_W-1:0]        fix_loc_i,
  output logic                     take_o,
  output logic [ADDR_W-1:0]        vaddr_o,
  output logic [15:0]              flags_o,
  output logic [2:0]               ipl_o,
  output logic [15:0]              save_flags_o,
  output logic [ADDR_W-1:0]        save_pc_o,
  output logic [NSRC-1:0]          clr_o
);
  logic              p_hit;
  logic [LVL_W-1:0]  p_prio;
  logic [VEC_W-1:0]  p_vec;
  logic [NSRC-1:0]   p_1h;
  entry_kind_e       kind;
  logic [VEC_W-1:0]  use_vec;
  logic [ADDR_W-1:0] nxt_addr;
  logic [FLAG_W-1:0] nxt_flags;

  irq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .en_i       (flags_i[BIT_IEN]),
    .lvl_i      (flags_i[LVL_LSB +: LVL_W]),
    .req_i      (req_i),
    .prio_i     (prio_i),
    .vec_i      (vec_i),
    .hit_o      (p_hit),
    .win_prio_o (p_prio),
    .win_vec_o  (p_vec),
    .win_1h_o   (p_1h)
  );

  // Class ranking; nothing starts while the previous strobe is out.
  always_comb begin
    if (take_o)         kind = ENT_NONE;
    else if (fix_req_i) kind = ENT_FIXED;
    else if (sw_req_i)  kind = ENT_SOFT;
    else if (p_hit)     kind = ENT_PERIPH;
    else                kind = ENT_NONE;
  end

  assign use_vec = (kind == ENT_SOFT) ? sw_vec_i : p_vec;

  irq_entry_calc #(.ADDR_W(ADDR_W), .VEC_W(VEC_W)) u_calc (
    .kind_i    (kind),
    .flags_i   (flags_i),
    .tbase_i   (tbase_i),
    .fix_loc_i (fix_loc_i),
    .vec_i     (use_vec),
    .prio_i    (p_prio),
    .vaddr_o   (nxt_addr),
    .flags_o   (nxt_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      take_o       <= 1'b0;
      clr_o        <= '0;
      vaddr_o      <= '0;
      flags_o      <= '0;
      save_flags_o <= '0;
      save_pc_o    <= '0;
    end else begin
      take_o <= (kind != ENT_NONE);
      clr_o  <= (kind == ENT_PERIPH) ? p_1h : '0;
      if (kind != ENT_NONE) begin
        vaddr_o      <= nxt_addr;
        flags_o      <= nxt_flags;
        save_flags_o <= flags_i;
        save_pc_o    <= pc_i;
      end
    end
  end

  assign ipl_o = flags_o[LVL_LSB +: LVL_W];
endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int NSRC   = 4,
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic [15:0]       flags_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic              take_o,
  input logic [15:0]       flags_o,
  input logic [15:0]       save_flags_o,
  input logic [ADDR_W-1:0] save_pc_o,
  input logic [NSRC-1:0]   clr_o
);
  AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(clr_o));                                              // R8
  AST_CLR_NEEDS_TAKE: assert property (@(posedge clk) disable iff (rst)
    (|clr_o) |-> take_o);                                          // R8
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    take_o |=> !take_o);                                           // R8
  AST_PERIPH_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (|clr_o) |-> $past(flags_i[6]));                               // R1
  AST_PERIPH_ABOVE_LVL: assert property (@(posedge clk) disable iff (rst)
    (|clr_o) |-> (flags_o[14:12] > $past(flags_i[14:12])));        // R6
  AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (!flags_o[6] && !flags_o[1]));                      // R4
  AST_PERIPH_STACK: assert property (@(posedge clk) disable iff (rst)
    (|clr_o) |-> !flags_o[7]);                                     // R5
  AST_SAVE_VALUES: assert property (@(posedge clk) disable iff (rst)
    take_o |-> (save_flags_o == $past(flags_i) && save_pc_o == $past(pc_i))); // R7
endmodule

bind irq_accept irq_accept_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .flags_i(flags_i), .pc_i(pc_i), .take_o(take_o),
  .flags_o(flags_o), .save_flags_o(save_flags_o), .save_pc_o(save_pc_o),
  .clr_o(clr_o)
);

// File: tb/irq_accept_test.sv
module irq_accept_test;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 4, VEC_W = 6, ADDR_W = 24;
  localparam int NV = 8;
  localparam logic [23:0] TBASE = 24'h001000;
  localparam logic [23:0] PCV   = 24'h00ABCD;
  localparam logic [23:0] FLOC  = 24'h00FFF0;
  localparam logic [23:0] VECS  = {6'd40, 6'd30, 6'd20, 6'd10};

  // flags, requests, priorities (src3..src0), expected winner (4 = none)
  localparam logic [15:0] T_FL  [NV] = '{16'h20C2, 16'h20C2, 16'h2082, 16'h50C2,
                                         16'h40C2, 16'h00C2, 16'h70C2, 16'h00C2};
  localparam logic [3:0]  T_RQ  [NV] = '{4'b0001, 4'b1111, 4'b1111, 4'b0101,
                                         4'b0101, 4'b1000, 4'b1111, 4'b0000};
  localparam logic [11:0] T_PR  [NV] = '{12'o0005, 12'o6361, 12'o7777, 12'o0405,
                                         12'o0405, 12'o1000, 12'o7777, 12'o7777};
  localparam logic [2:0]  T_WIN [NV] = '{3'd0, 3'd1, 3'd4, 3'd4,
                                         3'd0, 3'd3, 3'd4, 3'd4};

  logic clk = 0, rst = 1;
  logic [15:0] flags_i;
  logic [23:0] pc_i, tbase_i, fix_loc_i;
  logic [3:0]  req_i;
  logic [11:0] prio_i;
  logic [23:0] vec_i;
  logic sw_req_i, fix_req_i;
  logic [5:0] sw_vec_i;
  logic take_o;
  logic [23:0] vaddr_o, save_pc_o;
  logic [15:0] flags_o, save_flags_o;
  logic [2:0] ipl_o;
  logic [3:0] clr_o;

  int n_chk = 0, n_bad = 0;

  irq_accept #(.NSRC(NSRC), .VEC_W(VEC_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst(rst), .flags_i(flags_i), .pc_i(pc_i), .tbase_i(tbase_i),
    .req_i(req_i), .prio_i(prio_i), .vec_i(vec_i), .sw_req_i(sw_req_i),
    .sw_vec_i(sw_vec_i), .fix_req_i(fix_req_i), .fix_loc_i(fix_loc_i),
    .take_o(take_o), .vaddr_o(vaddr_o), .flags_o(flags_o), .ipl_o(ipl_o),
    .save_flags_o(save_flags_o), .save_pc_o(save_pc_o), .clr_o(clr_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_i = '0; sw_req_i = 0; fix_req_i = 0; sw_vec_i = '0;
  endtask

  // Peripheral entry expectation from R4/R5/R6: clear bits 6,1,7, level = prio.
  function automatic logic [15:0] periph_flags(input logic [15:0] f, input logic [2:0] p);
    logic [15:0] r;
    r = f & ~16'h00C2;
    r[14:12] = p;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD*20000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    flags_i = 16'h00C2; pc_i = PCV; tbase_i = TBASE; fix_loc_i = FLOC;
    prio_i = '0; vec_i = VECS; idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset take", take_o, 0);
    chk("R10 reset clr", clr_o, 0);
    rst = 0;
    @(negedge clk);
    chk("R10 after reset take", take_o, 0);

    // Table walk: R1 qualification, R2 arbitration, R3 address, R6 level
    for (int k = 0; k < NV; k++) begin
      flags_i = T_FL[k]; req_i = T_RQ[k]; prio_i = T_PR[k];
      @(negedge clk);
      if (T_WIN[k] == 3'd4) begin
        chk($sformatf("R1 row%0d no take", k), take_o, 0);
        chk($sformatf("R1 row%0d no clr", k), clr_o, 0);
      end else begin
        chk($sformatf("R1 row%0d take", k), take_o, 1);
        chk($sformatf("R2 row%0d clr", k), clr_o, 32'(4'b1 << T_WIN[k]));
        chk($sformatf("R3 row%0d addr", k), vaddr_o,
            32'(TBASE + 24'(VECS[T_WIN[k]*6 +: 6]) * 4));
        chk($sformatf("R6 row%0d flags", k), flags_o,
            32'(periph_flags(T_FL[k], T_PR[k][T_WIN[k]*3 +: 3])));
        chk($sformatf("R6 row%0d ipl", k), ipl_o, 32'(T_PR[k][T_WIN[k]*3 +: 3]));
        chk($sformatf("R7 row%0d save flags", k), save_flags_o, 32'(T_FL[k]));
        chk($sformatf("R7 row%0d save pc", k), save_pc_o, 32'(PCV));
      end
      idle();
      @(negedge clk);
    end

    // Software vector above 31: stack bit kept (R5), level kept
    flags_i = 16'h30C2; sw_req_i = 1; sw_vec_i = 6'd40;
    @(negedge clk); idle();
    chk("R3 soft40 addr", vaddr_o, 32'h0010A0);
    chk("R5 soft40 flags", flags_o, 32'h3080);
    chk("R6 soft40 ipl", ipl_o, 3);
    chk("R8 soft clr", clr_o, 0);
    @(negedge clk);

    // Software vector 31 boundary: stack bit cleared (R5)
    sw_req_i = 1; sw_vec_i = 6'd31;
    @(negedge clk); idle();
    chk("R3 soft31 addr", vaddr_o, 32'h00107C);
    chk("R5 soft31 flags", flags_o, 32'h3000);
    @(negedge clk);

    // Fixed entry: address is the location itself, stack bit cleared (R4, R5)
    fix_req_i = 1;
    @(negedge clk); idle();
    chk("R3 fixed addr", vaddr_o, 32'(FLOC));
    chk("R4 fixed flags", flags_o, 32'h3000);
    @(negedge clk);

    // Fixed and peripheral together: fixed wins, peripheral stays pending (R9)
    flags_i = 16'h00C2; req_i = 4'b0001; prio_i = 12'o0007; fix_req_i = 1;
    @(negedge clk);
    fix_req_i = 0;
    chk("R9 fixed wins take", take_o, 1);
    chk("R9 fixed wins addr", vaddr_o, 32'(FLOC));
    chk("R9 peripheral not cleared", clr_o, 0);
    @(negedge clk);
    chk("R8 blocked after strobe", take_o, 0);
    @(negedge clk);
    chk("R9 pending peripheral taken", take_o, 1);
    chk("R9 pending peripheral clr", clr_o, 1);
    chk("R6 pending peripheral ipl", ipl_o, 7);
    @(negedge clk);
    chk("R8 no back-to-back", take_o, 0);
    idle();
    @(negedge clk);

    // Software beats peripheral (R9)
    req_i = 4'b0001; sw_req_i = 1; sw_vec_i = 6'd5;
    @(negedge clk); idle();
    chk("R9 soft beats peripheral addr", vaddr_o, 32'h001014);
    chk("R9 soft beats peripheral clr", clr_o, 0);
    chk("R6 soft keeps level", ipl_o, 0);
    @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule